// File: doc/BRIEF.md
# Indexed Postbyte Address Generator

This block turns a one-byte indexed-addressing descriptor into an effective operand address. A caller presents the descriptor byte with a one-cycle `start` strobe, together with the current values of the four index registers and the two 8-bit accumulators. The block decodes which base register and which offset source the byte asks for. It pulls any extension bytes it needs over a byte fetch handshake, and for the indirect forms it reads a word through a request/acknowledge read port. It then raises `done` for one cycle with the effective address, a count of extra cycles, and, for the auto-modify forms, the new value that the caller must write back to the base register.

The 2-bit base code means 0 = X, 1 = Y, 2 = SP and 3 = PC. Register and accumulator values are captured in the `start` cycle. The PC value is used exactly as presented. A `restricted` flag, also sampled with `start`, tells the block that the current instruction allows neither extension bytes nor indirection. A descriptor that needs either one is then reported as invalid and not executed.

Top module: `ipx_addr_gen`

## Requirements
- R1: Descriptor bit 5 = 0 selects constant mode: the address is the base selected by bits 7:6 plus the sign-extended 5-bit value in bits 4:0 (bit 4 is the sign). Base code 0 is X, 1 is Y, 2 is SP and 3 is PC.
- R2: Bit 5 = 1 with bits 7:6 not equal to 11 selects auto-modify on the base chosen by bits 7:6. Bits 3:0 give the amount: if bit 3 = 0 the amount is +(value+1), in the range +1..+8; if bit 3 = 1 it is value-16, in the range -8..-1. With `done`, `wb_en` pulses, `wb_sel` carries the base code and `wb_val` carries base+amount.
- R3: In auto-modify mode bit 4 = 0 makes the address the modified value (pre) and bit 4 = 1 makes it the unmodified base (post).
- R4: Bits 7:6 = 11 take the base code from bits 4:3. Bits 2:0 = 000 or 001 fetch one extension byte, and the offset is that byte with bit 0 as a ninth sign bit (byte-256 when bit 0 = 1). `extra` is 0.
- R5: Bits 7:6 = 11 with bits 2:0 = 010 fetch two extension bytes, high byte first, add the 16-bit offset, and report `extra` = 1.
- R6: Bits 7:6 = 11 with bits 2:0 = 011 fetch a 16-bit offset, read the word at base+offset, and return that word as the address. `extra` is 1. While waiting for `rd_ack`, `rd_req` and `rd_addr` hold steady.
- R7: Bits 7:6 = 11 with bit 2 = 1 use an accumulator offset, zero-extended: 100 adds A, 101 adds B, 110 adds D = {A,B}. 111 adds D, then reads the word at that sum and returns it, with `extra` = 1.
- R8: If `restricted` is high and the descriptor needs extension bytes or an indirect read, the block raises `done` with `invalid` = 1, `ea` = 0, `extra` = 0 and no `wb_en`, and it issues no fetch or read. Constant, auto-modify and non-indirect accumulator forms remain valid.
- R9: All address sums wrap modulo 65536.
- R10: `done` lasts one cycle. It comes one cycle after `start` when nothing is fetched or read. Otherwise it comes one cycle after the last `fetch_ack` or `rd_ack`.
- R11: Register and accumulator inputs are sampled only in the `start` cycle; changes afterwards do not affect the result.
- R12: Constant, auto-modify, 8-bit-offset and the non-indirect accumulator forms report `extra` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin decoding `postbyte` (accepted when idle) |
| restricted | input | 1 | Instruction forbids extension bytes and indirection |
| postbyte | input | 8 | Indexed addressing descriptor |
| reg_x | input | 16 | Index register X |
| reg_y | input | 16 | Index register Y |
| reg_sp | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter value used as base |
| acc_a | input | 8 | Accumulator A |
| acc_b | input | 8 | Accumulator B |
| fetch_req | output | 1 | Request for the next extension byte |
| fetch_ack | input | 1 | Extension byte valid on `fetch_data` |
| fetch_data | input | 8 | Extension byte |
| rd_req | output | 1 | Indirect word read request |
| rd_addr | output | 16 | Indirect read address |
| rd_ack | input | 1 | Read word valid on `rd_data` |
| rd_data | input | 16 | Word returned by the read |
| done | output | 1 | Result valid (one cycle) |
| invalid | output | 1 | Descriptor rejected under `restricted` |
| ea | output | 16 | Effective address |
| extra | output | 2 | Extra cycle count |
| wb_en | output | 1 | Base register write-back strobe |
| wb_sel | output | 2 | Base register code to write |
| wb_val | output | 16 | Modified base value |

## Verification
The bench targets the sign boundaries of each offset: the most negative 5-bit constant, amounts of -8, -1, +1 and +8, and a 9-bit offset of -128. A design that zero-extends any of these, or that maps the 4-bit auto amount as a plain two's-complement value, lands on an address that is off by a power of two. Pre and post forms are paired on the same register, so a design that swaps them returns the write-back value as the address. Indirect forms check both the read address and the returned word. The bench also changes the register inputs while bytes are still being fetched, which exposes a design that reads registers after the `start` cycle. The restricted cases confirm that no fetch appears and that accumulator forms are not wrongly rejected.

// File: rtl/ipx_pkg.sv
package ipx_pkg;

   // Offset source chosen by the descriptor byte
   typedef enum logic [3:0] {
      IPX_CONST     = 4'd0,
      IPX_AUTO      = 4'd1,
      IPX_OFS8      = 4'd2,
      IPX_OFS16     = 4'd3,
      IPX_OFS16_IND = 4'd4,
      IPX_ACC_A     = 4'd5,
      IPX_ACC_B     = 4'd6,
      IPX_ACC_D     = 4'd7,
      IPX_ACC_D_IND = 4'd8
   } ipx_mode_e;

   // Base register code: fixed order, the caller decodes wb_sel with it
   typedef enum logic [1:0] {
      IPX_RX  = 2'd0,
      IPX_RY  = 2'd1,
      IPX_RSP = 2'd2,
      IPX_RPC = 2'd3
   } ipx_reg_e;

   typedef struct packed {
      ipx_mode_e  mode;
      ipx_reg_e   base;
      logic [1:0] n_ext;     // extension bytes to fetch
      logic       indirect;  // word read after the sum
      logic       post;      // auto-modify: address is unmodified base
      logic       heavy;     // needs extension bytes or indirection
      logic       slow;      // costs one extra cycle
   } ipx_dec_t;

   typedef enum logic [1:0] {
      IPX_S_IDLE = 2'd0,
      IPX_S_EXT  = 2'd1,
      IPX_S_READ = 2'd2,
      IPX_S_FIN  = 2'd3
   } ipx_state_e;

endpackage

// File: rtl/ipx_decode.sv
module ipx_decode
   import ipx_pkg::*;
(
   input  logic [7:0] pb,
   output ipx_dec_t   dec
);

   logic grp_hi;
   assign grp_hi = (pb[7:6] == 2'b11);

   always_comb begin
      dec          = '0;
      dec.mode     = IPX_CONST;
      dec.base     = ipx_reg_e'(pb[7:6]);
      if (!pb[5]) begin
         // R1: constant offset, base from bits 7:6
         dec.mode = IPX_CONST;
      end else if (!grp_hi) begin
         // R2/R3: auto-modify, bit 4 picks post
         dec.mode = IPX_AUTO;
         dec.post = pb[4];
      end else begin
         dec.base = ipx_reg_e'(pb[4:3]);
         unique case (pb[2:0])
            3'b000, 3'b001: begin  // R4
               dec.mode  = IPX_OFS8;
               dec.n_ext = 2'd1;
            end
            3'b010: begin          // R5
               dec.mode  = IPX_OFS16;
               dec.n_ext = 2'd2;
               dec.slow  = 1'b1;
            end
            3'b011: begin          // R6
               dec.mode     = IPX_OFS16_IND;
               dec.n_ext    = 2'd2;
               dec.indirect = 1'b1;
               dec.slow     = 1'b1;
            end
            3'b100: dec.mode = IPX_ACC_A;   // R7
            3'b101: dec.mode = IPX_ACC_B;
            3'b110: dec.mode = IPX_ACC_D;
            default: begin
               dec.mode     = IPX_ACC_D_IND;
               dec.indirect = 1'b1;
               dec.slow     = 1'b1;
            end
         endcase
      end
      // R8: forms that a restricted instruction may not use
      dec.heavy = (dec.n_ext != 2'd0) || dec.indirect;
   end

endmodule

// File: rtl/ipx_offset.sv
module ipx_offset
   import ipx_pkg::*;
#(
   parameter int AW = 16
) (
   input  ipx_mode_e        mode,
   input  logic [4:0]       pb_lo,
   input  logic [15:0]      ext,
   input  logic [7:0]       acc_a,
   input  logic [7:0]       acc_b,
   input  logic [AW-1:0]    base,
   output logic [AW-1:0]    sum
);

   localparam int HI_W = AW - 16;

   logic [AW-1:0] ext16_sx;
   logic [AW-1:0] off;

   // Width variant of the 16-bit offset sign extension
   generate
      if (AW > 16) begin : g_wide
         assign ext16_sx = {{HI_W{ext[15]}}, ext};
      end else begin : g_narrow
         assign ext16_sx = ext;
      end
   endgenerate

   always_comb begin
      unique case (mode)
         IPX_CONST:  off = AW'($signed(pb_lo));                     // R1
         IPX_AUTO:   off = pb_lo[3] ? AW'($signed(pb_lo[3:0]))      // R2: -8..-1
                                    : AW'(pb_lo[3:0]) + AW'(1);     // R2: +1..+8
         IPX_OFS8:   off = AW'($signed({pb_lo[0], ext[7:0]}));      // R4
         IPX_OFS16, IPX_OFS16_IND: off = ext16_sx;                  // R5, R6
         IPX_ACC_A:  off = AW'(acc_a);                              // R7
         IPX_ACC_B:  off = AW'(acc_b);
         default:    off = AW'({acc_a, acc_b});
      endcase
   end

   // R9: plain modular add
   assign sum = base + off;

endmodule

// File: rtl/ipx_addr_gen.sv
module ipx_addr_gen
   import ipx_pkg::*;
#(
   parameter int AW = 16,
   parameter int XW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          restricted,
   input  logic [7:0]    postbyte,
   input  logic [AW-1:0] reg_x,
   input  logic [AW-1:0] reg_y,
   input  logic [AW-1:0] reg_sp,
   input  logic [AW-1:0] reg_pc,
   input  logic [7:0]    acc_a,
   input  logic [7:0]    acc_b,
   output logic          fetch_req,
   input  logic          fetch_ack,
   input  logic [7:0]    fetch_data,
   output logic          rd_req,
   output logic [AW-1:0] rd_addr,
   input  logic          rd_ack,
   input  logic [AW-1:0] rd_data,
   output logic          done,
   output logic          invalid,
   output logic [AW-1:0] ea,
   output logic [XW-1:0] extra,
   output logic          wb_en,
   output logic [1:0]    wb_sel,
   output logic [AW-1:0] wb_val
);

   initial begin
      assert (AW >= 16) else $error("ipx_addr_gen: AW below 16");
      assert (XW >= 1)  else $error("ipx_addr_gen: XW below 1");
   end

   ipx_state_e    state_q;
   logic [7:0]    pb_q;
   logic          inv_q;
   logic [AW-1:0] base_q;
   logic [7:0]    a_q, b_q;
   logic [15:0]   ext_q;
   logic [1:0]    cnt_q;
   logic [AW-1:0] word_q;

   logic [7:0]    pb_cur;
   ipx_dec_t      dec;
   logic [AW-1:0] base_in;
   logic [AW-1:0] sum;
   logic          idle;

   assign idle   = (state_q == IPX_S_IDLE);
   assign pb_cur = idle ? postbyte : pb_q;

   ipx_decode u_dec (
      .pb  (pb_cur),
      .dec (dec)
   );

   // R1: base code order X, Y, SP, PC
   always_comb begin
      unique case (dec.base)
         IPX_RX:  base_in = reg_x;
         IPX_RY:  base_in = reg_y;
         IPX_RSP: base_in = reg_sp;
         default: base_in = reg_pc;
      endcase
   end

   ipx_offset #(.AW(AW)) u_ofs (
      .mode  (dec.mode),
      .pb_lo (pb_q[4:0]),
      .ext   (ext_q),
      .acc_a (a_q),
      .acc_b (b_q),
      .base  (base_q),
      .sum   (sum)
   );

   // R11: everything captured in the start cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= IPX_S_IDLE;
         pb_q    <= '0;
         inv_q   <= 1'b0;
         base_q  <= '0;
         a_q     <= '0;
         b_q     <= '0;
         ext_q   <= '0;
         cnt_q   <= '0;
         word_q  <= '0;
      end else begin
         unique case (state_q)
            IPX_S_IDLE: if (start) begin
               pb_q   <= postbyte;
               base_q <= base_in;
               a_q    <= acc_a;
               b_q    <= acc_b;
               ext_q  <= '0;
               word_q <= '0;
               cnt_q  <= dec.n_ext;
               inv_q  <= restricted && dec.heavy;
               if (restricted && dec.heavy)   state_q <= IPX_S_FIN;  // R8
               else if (dec.n_ext != 2'd0)    state_q <= IPX_S_EXT;
               else if (dec.indirect)         state_q <= IPX_S_READ;
               else                           state_q <= IPX_S_FIN;
            end
            IPX_S_EXT: if (fetch_ack) begin
               ext_q <= {ext_q[7:0], fetch_data};  // R5: high byte first
               cnt_q <= 2'(cnt_q - 2'd1);
               if (cnt_q == 2'd1)
                  state_q <= dec.indirect ? IPX_S_READ : IPX_S_FIN;
            end
            IPX_S_READ: if (rd_ack) begin
               word_q  <= rd_data;
               state_q <= IPX_S_FIN;
            end
            default: state_q <= IPX_S_IDLE;
         endcase
      end
   end

   logic ok;
   assign ok = done && !inv_q;

   assign fetch_req = (state_q == IPX_S_EXT);
   assign rd_req    = (state_q == IPX_S_READ);
   assign rd_addr   = sum;
   assign done      = (state_q == IPX_S_FIN);
   assign invalid   = done && inv_q;
   assign extra     = (ok && dec.slow) ? XW'(1) : '0;      // R5, R6, R7, R12
   assign wb_en     = ok && (dec.mode == IPX_AUTO);        // R2
   assign wb_sel    = dec.base;
   assign wb_val    = sum;

   always_comb begin
      if (!ok)                                     ea = '0;
      else if (dec.indirect)                       ea = word_q;   // R6, R7
      else if (dec.mode == IPX_AUTO && dec.post)   ea = base_q;   // R3
      else                                         ea = sum;
   end

   // ---------------- assertions ----------------
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R10
   AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (done && !invalid));                                  // R2
   AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      invalid |-> (!wb_en && extra == '0 && ea == '0));               // R8
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));          // R6
   AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_req && rd_req));                                        // R10
   AST_RESTRICT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && start && restricted && dec.heavy) |=> (done && !fetch_req && !rd_req)); // R8

endmodule

// File: tb/tb_ipx_addr_gen.sv
`timescale 1ns/1ps
module tb_ipx_addr_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        restricted = 1'b0;
   logic [7:0]  postbyte = '0;
   logic [15:0] reg_x = 16'h1000, reg_y = 16'h2000, reg_sp = 16'h3000, reg_pc = 16'h4000;
   logic [7:0]  acc_a = 8'h12, acc_b = 8'h34;
   logic        fetch_req, fetch_ack = 1'b0;
   logic [7:0]  fetch_data = '0;
   logic        rd_req, rd_ack = 1'b0;
   logic [15:0] rd_addr, rd_data = '0;
   logic        done, invalid, wb_en;
   logic [15:0] ea, wb_val;
   logic [1:0]  extra, wb_sel;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;  // 250 MHz

   ipx_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .start(start), .restricted(restricted),
      .postbyte(postbyte), .reg_x(reg_x), .reg_y(reg_y), .reg_sp(reg_sp),
      .reg_pc(reg_pc), .acc_a(acc_a), .acc_b(acc_b),
      .fetch_req(fetch_req), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .done(done), .invalid(invalid), .ea(ea), .extra(extra),
      .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val)
   );

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // One scenario: drive descriptor, serve fetches/reads, check the result
   task automatic run(string tag, logic [7:0] pb, logic restr,
                      logic [7:0] b0, logic [7:0] b1, logic [15:0] word,
                      logic [15:0] exp_ea, logic [1:0] exp_extra,
                      logic exp_wb, logic [1:0] exp_sel, logic [15:0] exp_wbv,
                      logic exp_inv, logic [15:0] exp_rda, int exp_lat,
                      bit scramble);
      int cyc = 1;
      int fi = 0;
      bit got = 0;
      logic [15:0] sx = reg_x, sy = reg_y, ssp = reg_sp, spc = reg_pc;
      logic [7:0]  sa = acc_a, sb = acc_b;
      @(negedge clk);
      postbyte = pb; restricted = restr; start = 1'b1;
      @(negedge clk);
      start = 1'b0; postbyte = ~pb; restricted = ~restr;
      if (scramble) begin
         reg_x = ~reg_x; reg_y = ~reg_y; reg_sp = ~reg_sp; reg_pc = ~reg_pc;
         acc_a = ~acc_a; acc_b = ~acc_b;
      end
      while (!got && cyc < 40) begin
         fetch_ack = 1'b0; rd_ack = 1'b0;
         if (done) begin
            got = 1;
         end else begin
            if (fetch_req) begin
               fetch_ack = 1'b1; fetch_data = (fi == 0) ? b0 : b1; fi++;
            end
            if (rd_req) begin
               chk(tag, "rd_addr", 32'(rd_addr), 32'(exp_rda));
               rd_ack = 1'b1; rd_data = word;
            end
            @(negedge clk); cyc++;
         end
      end
      fetch_ack = 1'b0; rd_ack = 1'b0;
      if (!got) begin
         n_chk++; n_bad++;
         $display("FAIL %s R10 done: actual none expected after %0d cycles", tag, exp_lat);
      end else begin
         chk({tag, " R10"}, "latency", 32'(cyc), 32'(exp_lat));
         chk(tag, "ea", 32'(ea), 32'(exp_ea));
         chk(tag, "extra", 32'(extra), 32'(exp_extra));
         chk(tag, "invalid", 32'(invalid), 32'(exp_inv));
         chk(tag, "wb_en", 32'(wb_en), 32'(exp_wb));
         if (exp_wb) begin
            chk(tag, "wb_sel", 32'(wb_sel), 32'(exp_sel));
            chk(tag, "wb_val", 32'(wb_val), 32'(exp_wbv));
         end
         if (exp_inv) chk({tag, " R8"}, "fetches", 32'(fi), 32'd0);
         @(negedge clk);
         chk({tag, " R10"}, "done pulse", 32'(done), 32'd0);
      end
      reg_x = sx; reg_y = sy; reg_sp = ssp; reg_pc = spc; acc_a = sa; acc_b = sb;
   endtask

   task automatic t_reset;
      chk("R10 reset", "done", 32'(done), 32'd0);
      chk("R10 reset", "fetch_req", 32'(fetch_req), 32'd0);
      chk("R10 reset", "rd_req", 32'(rd_req), 32'd0);
      chk("R2 reset", "wb_en", 32'(wb_en), 32'd0);
   endtask

   task automatic t_const;  // R1 R12
      run("R1 X+5", 8'h05, 0, 0, 0, 0, 16'h1005, 0, 0, 0, 0, 0, 0, 1, 0);
      run("R1 Y-16", 8'h50, 0, 0, 0, 0, 16'h1FF0, 0, 0, 0, 0, 0, 0, 1, 0);
      run("R1 SP-1", 8'h9F, 0, 0, 0, 0, 16'h2FFF, 0, 0, 0, 0, 0, 0, 1, 0);
      run("R1 R12 PC+15", 8'hCF, 0, 0, 0, 0, 16'h400F, 0, 0, 0, 0, 0, 0, 1, 0);
      reg_x = 16'hFFFE;
      run("R9 wrap", 8'h03, 0, 0, 0, 0, 16'h0001, 0, 0, 0, 0, 0, 0, 1, 0);
      reg_x = 16'h1000;
   endtask

   task automatic t_auto;  // R2 R3 R12
      run("R2 R3 pre+1 X", 8'h20, 0, 0, 0, 0, 16'h1001, 0, 1, 2'd0, 16'h1001, 0, 0, 1, 0);
      run("R2 R3 post-1 Y", 8'h7F, 0, 0, 0, 0, 16'h2000, 0, 1, 2'd1, 16'h1FFF, 0, 0, 1, 0);
      run("R2 R3 pre-8 SP", 8'hA8, 0, 0, 0, 0, 16'h2FF8, 0, 1, 2'd2, 16'h2FF8, 0, 0, 1, 0);
      run("R2 R3 R12 post+8 X", 8'h37, 0, 0, 0, 0, 16'h1000, 0, 1, 2'd0, 16'h1008, 0, 0, 1, 0);
   endtask

   task automatic t_ext;  // R4 R5 R6 R11
      run("R4 Y+127", 8'hE8, 0, 8'h7F, 0, 0, 16'h207F, 0, 0, 0, 0, 0, 0, 2, 0);
      run("R4 SP-128", 8'hF1, 0, 8'h80, 0, 0, 16'h2F80, 0, 0, 0, 0, 0, 0, 2, 0);
      run("R5 PC+1234", 8'hFA, 0, 8'h12, 8'h34, 0, 16'h5234, 1, 0, 0, 0, 0, 0, 3, 0);
      run("R6 [X+16]", 8'hE3, 0, 8'h00, 8'h10, 16'hBEEF, 16'hBEEF, 1, 0, 0, 0, 0, 16'h1010, 4, 0);
      run("R11 R5 scrambled", 8'hEA, 0, 8'hFF, 8'hF0, 0, 16'h1FF0, 1, 0, 0, 0, 0, 0, 3, 1);
   endtask

   task automatic t_acc;  // R7
      acc_a = 8'h80;
      run("R7 X+A", 8'hE4, 0, 0, 0, 0, 16'h1080, 0, 0, 0, 0, 0, 0, 1, 0);
      acc_b = 8'hFF;
      run("R7 Y+B", 8'hED, 0, 0, 0, 0, 16'h20FF, 0, 0, 0, 0, 0, 0, 1, 0);
      acc_a = 8'hE0; acc_b = 8'h10;
      run("R7 R9 SP+D", 8'hF6, 0, 0, 0, 0, 16'h1010, 0, 0, 0, 0, 0, 0, 1, 0);
      acc_a = 8'h12; acc_b = 8'h34;
      run("R7 [PC+D]", 8'hFF, 0, 0, 0, 16'hCAFE, 16'hCAFE, 1, 0, 0, 0, 0, 16'h5234, 2, 0);
   endtask

   task automatic t_restricted;  // R8
      run("R8 ext16 rejected", 8'hFA, 1, 8'h12, 8'h34, 0, 16'h0000, 0, 0, 0, 0, 1, 0, 1, 0);
      run("R8 ext8 rejected", 8'hE8, 1, 8'h12, 0, 0, 16'h0000, 0, 0, 0, 0, 1, 0, 1, 0);
      run("R8 [D] rejected", 8'hFF, 1, 0, 0, 16'hCAFE, 16'h0000, 0, 0, 0, 0, 1, 0, 1, 0);
      run("R8 acc A allowed", 8'hE4, 1, 0, 0, 0, 16'h1012, 0, 0, 0, 0, 0, 0, 1, 0);
      run("R8 const allowed", 8'h05, 1, 0, 0, 0, 16'h1005, 0, 0, 0, 0, 0, 0, 1, 0);
      run("R8 auto allowed", 8'h20, 1, 0, 0, 0, 16'h1001, 0, 1, 2'd0, 16'h1001, 0, 0, 1, 0);
   endtask

   initial begin
      #200000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_const();
      t_auto();
      t_ext();
      t_acc();
      t_restricted();
      repeat (2) @(negedge clk);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule